// File: doc/BRIEF.md
# Multi-Port Retry Front End

This block lets several requester ports share one cache engine that can work on only a single request at a time. Each port has a request channel with valid and accept, a response channel with valid and ready, and a retry output. A request that cannot be taken is turned away at once. A rejected requester does not poll the block. It waits until its port raises a one-cycle retry pulse, and that pulse is sent only when the port holds no stalled response and the engine is idle.

When several ports ask in the same cycle, a round-robin arbiter picks one winner. The block passes the winning payload to the engine and records which port it came from. When the engine answers, the response goes back to that port and to no other. If the requester does not take the response, the port keeps it in a one-entry holding register and presents it again until the requester accepts it.

The engine counts as free again in the cycle its response arrives. A port, including the port being answered, can therefore start a new request in that same cycle. All ports that owe a retry re-evaluate whenever the engine becomes idle or their held response drains.

Top module: `retry_front_end`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_accept`, `rsp_valid`, `retry` and `eng_req_valid` are all zero.
- R2: An accepted request is visible in the same cycle. `req_accept[i]` is high only when `req_valid[i]` is high, `eng_req_valid` is high, and `eng_req_data` equals the `req_data` slice of port i (slice i is bits i*QW to i*QW+QW-1).
- R3: At most one request is outstanding at a time. From the cycle after an accept until the cycle in which `eng_rsp_valid` arrives, every request is rejected, and each rejecting port owes its requester a retry.
- R4: When several eligible ports request in the same cycle, the grant goes to the first requesting port found by scanning upward from a pointer, with wrap-around. The pointer is port 0 after reset and moves to the winner plus one after each grant. Every losing port is rejected and owes a retry.
- R5: A response from the engine appears on `rsp_valid` and `rsp_data` of the originating port only, in the same cycle as `eng_rsp_valid`.
- R6: If a port drops `rsp_ready` while its response is valid, the port holds that response. It keeps `rsp_valid` high with the same data until `rsp_ready` is high, and it rejects its own requests while the response is held.
- R7: `retry[i]` is high when port i owes a retry, holds no response, and no request is outstanding. The pulse lasts one cycle unless the requester is rejected again in that same cycle.
- R8: A port that owes a retry rejects a request presented before or during its retry pulse, even when the engine is idle. That rejection keeps the retry owed.
- R9: In the cycle `eng_rsp_valid` arrives, the engine counts as free. A request from any other port, or from the answered port when its `rsp_ready` is high, is accepted in that cycle. The answered port is rejected if it refuses the response.
- R10: When the engine becomes idle, every port that owes a retry and holds no response raises its retry in the same cycle, not only the port that was served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-port request present |
| req_data | input | N*QW | Per-port request payload, port i in slice i |
| req_accept | output | N | Per-port request taken this cycle |
| rsp_valid | output | N | Per-port response present |
| rsp_data | output | N*RW | Per-port response payload |
| rsp_ready | input | N | Per-port requester can take the response |
| retry | output | N | Per-port one-cycle pulse meaning "try again" |
| eng_req_valid | output | 1 | Request handed to the engine this cycle |
| eng_req_data | output | QW | Payload handed to the engine |
| eng_rsp_valid | input | 1 | Engine returns a response this cycle |
| eng_rsp_data | input | RW | Engine response payload |

## Verification
The checker assumes that the engine raises `eng_rsp_valid` only while a request is outstanding, and at most once for each accepted request. The routing and single-outstanding properties rely on that assumption. The retry-pulse property also assumes the requester is quiet during the pulse cycle; the bench breaks this only in the one step that exercises R8.

The bench plays the engine itself. It answers only after it has seen an accept, so every response matches a real outstanding request. It sweeps every non-empty request mask across the three ports, and the checks in each step follow a round-robin pointer that the bench keeps on its own.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    // Advance a circular index with wrap at n.
    function automatic int unsigned rfe_wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

    // Index of the lowest set bit of a vector, 0 when none is set.
    function automatic int unsigned rfe_low_index(logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) r = k;
        end
        return r;
    endfunction

endpackage

// File: rtl/rfe_rr_arb.sv
module rfe_rr_arb
    import rfe_pkg::*;
#(
    parameter int unsigned N  = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any_grant
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        grant     = '0;
        grant_idx = '0;
        any_grant = 1'b0;
        for (int unsigned k = 0; k < N; k++) begin
            int unsigned c;
            c = (int'(st_q.ptr) + k) % N;
            if (!any_grant && elig[c]) begin
                any_grant = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = IW'(c);
                st_d.ptr  = IW'(rfe_wrap_inc(c, N));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rfe_port_slot.sv
module rfe_port_slot #(
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          granted,
    input  logic          eng_idle,
    input  logic          fresh_valid,
    input  logic [RW-1:0] fresh_data,
    input  logic          rsp_ready,
    output logic          can_take,
    output logic          rsp_valid,
    output logic [RW-1:0] rsp_data,
    output logic          retry
);

    typedef struct packed {
        logic          held;
        logic [RW-1:0] held_data;
        logic          owed;
    } slot_st_t;

    slot_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        rsp_valid = st_q.held | fresh_valid;
        rsp_data  = st_q.held ? st_q.held_data : fresh_data;
        can_take  = !st_q.held && !st_q.owed && !(fresh_valid && !rsp_ready);
        retry     = st_q.owed && !st_q.held && eng_idle;

        st_d.owed = (st_q.owed && !retry) || (req_valid && !granted);

        if (rsp_valid && !rsp_ready) begin
            st_d.held      = 1'b1;
            st_d.held_data = rsp_data;
        end else if (rsp_valid) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/retry_front_end.sv
module retry_front_end #(
    parameter int unsigned N  = 3,
    parameter int unsigned QW = 8,
    parameter int unsigned RW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N*QW-1:0] req_data,
    output logic [N-1:0]    req_accept,
    output logic [N-1:0]    rsp_valid,
    output logic [N*RW-1:0] rsp_data,
    input  logic [N-1:0]    rsp_ready,
    output logic [N-1:0]    retry,
    output logic            eng_req_valid,
    output logic [QW-1:0]   eng_req_data,
    input  logic            eng_rsp_valid,
    input  logic [RW-1:0]   eng_rsp_data
);

    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] owner;
    } eng_st_t;

    eng_st_t st_q, st_d;

    logic [N-1:0]  can_take;
    logic [N-1:0]  elig;
    logic [N-1:0]  grant;
    logic [N-1:0]  fresh_valid;
    logic [IW-1:0] grant_idx;
    logic          any_grant;
    logic          eng_free;

    always_comb begin
        eng_free = !st_q.busy || eng_rsp_valid;
        elig     = req_valid & can_take & {N{eng_free}};
        for (int unsigned i = 0; i < N; i++) begin
            fresh_valid[i] = eng_rsp_valid && (st_q.owner == IW'(i));
        end
    end

    rfe_rr_arb #(.N(N)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any_grant (any_grant)
    );

    always_comb begin
        st_d          = st_q;
        req_accept    = grant;
        eng_req_valid = any_grant;
        eng_req_data  = req_data[grant_idx*QW +: QW];
        if (eng_rsp_valid) begin
            st_d.busy  = 1'b0;
            st_d.owner = '0;
        end
        if (any_grant) begin
            st_d.busy  = 1'b1;
            st_d.owner = grant_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_port
        rfe_port_slot #(.RW(RW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid   (req_valid[g]),
            .granted     (grant[g]),
            .eng_idle    (!st_q.busy),
            .fresh_valid (fresh_valid[g]),
            .fresh_data  (eng_rsp_data),
            .rsp_ready   (rsp_ready[g]),
            .can_take    (can_take[g]),
            .rsp_valid   (rsp_valid[g]),
            .rsp_data    (rsp_data[g*RW +: RW]),
            .retry       (retry[g])
        );
    end

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
    parameter int unsigned N  = 3,
    parameter int unsigned QW = 8,
    parameter int unsigned RW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    req_valid,
    input logic [N*QW-1:0] req_data,
    input logic [N-1:0]    req_accept,
    input logic [N-1:0]    rsp_valid,
    input logic [N*RW-1:0] rsp_data,
    input logic [N-1:0]    rsp_ready,
    input logic [N-1:0]    retry,
    input logic            eng_req_valid,
    input logic [QW-1:0]   eng_req_data,
    input logic            eng_rsp_valid,
    input logic [RW-1:0]   eng_rsp_data
);

    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic          outst_q;
    logic [IW-1:0] own_q;
    logic [IW-1:0] acc_idx;

    always_comb begin
        acc_idx = '0;
        for (int unsigned i = 0; i < N; i++) begin
            if (req_accept[i]) acc_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
            own_q   <= '0;
        end else if (eng_req_valid) begin
            outst_q <= 1'b1;
            own_q   <= acc_idx;
        end else if (eng_rsp_valid) begin
            outst_q <= 1'b0;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid |-> (!outst_q || eng_rsp_valid)); // R3
    AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_accept)); // R4
    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept & ~req_valid) == '0); // R2
    AST_RSP_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rsp_valid && outst_q) |-> rsp_valid[own_q]); // R5

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (retry[g] && !req_valid[g]) |=> !retry[g]); // R7
        AST_RETRY_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            retry[g] |-> !rsp_valid[g]); // R7
        AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[g] && !rsp_ready[g]) |=>
                (rsp_valid[g] && $stable(rsp_data[g*RW +: RW]))); // R6
        AST_HELD_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[g] && !rsp_ready[g]) |=> !req_accept[g]); // R6
    end

endmodule

bind retry_front_end rfe_checker #(.N(N), .QW(QW), .RW(RW)) u_chk (.*);

// File: tb/retry_front_end_test.sv
`timescale 1ns/1ps
module retry_front_end_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  req_valid;
    logic [23:0] req_data;
    logic [2:0]  req_accept;
    logic [2:0]  rsp_valid;
    logic [23:0] rsp_data;
    logic [2:0]  rsp_ready;
    logic [2:0]  retry;
    logic        eng_req_valid;
    logic [7:0]  eng_req_data;
    logic        eng_rsp_valid;
    logic [7:0]  eng_rsp_data;

    int checks = 0;
    int fails  = 0;
    int rr     = 0;

    always #5 clk = ~clk;

    retry_front_end uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_data(req_data), .req_accept(req_accept),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
        .retry(retry),
        .eng_req_valid(eng_req_valid), .eng_req_data(eng_req_data),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_data(eng_rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    function automatic int pick(input int m, input int p);
        for (int k = 0; k < 3; k++) begin
            int c;
            c = (p + k) % 3;
            if (m[c]) return c;
        end
        return 0;
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = '0; req_data = '0; rsp_ready = '0;
        eng_rsp_valid = 1'b0; eng_rsp_data = '0;
        repeat (3) cyc();
        #1;
        chk("R1 reset accept", 32'(req_accept), 0);
        chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R1 reset retry", 32'(retry), 0);
        chk("R1 reset eng_req_valid", 32'(eng_req_valid), 0);
        cyc();
        rst_n = 1'b1;
        #1;
        chk("R1 after reset retry", 32'(retry), 0);
        chk("R1 after reset rsp_valid", 32'(rsp_valid), 0);

        // Sweep of every non-empty request mask
        for (int m = 1; m < 8; m++) begin
            int win;
            cyc();
            win = pick(m, rr);
            req_valid = 3'(m);
            for (int p = 0; p < 3; p++) req_data[p*8 +: 8] = 8'(p * 16 + m);
            rsp_ready = 3'b111;
            #1;
            chk("R4 round-robin grant", 32'(req_accept), 32'(1 << win));
            chk("R2 engine valid", 32'(eng_req_valid), 1);
            chk("R2 engine payload", 32'(eng_req_data), 32'(win * 16 + m));
            rr = (win + 1) % 3;
            cyc();
            req_valid = 3'(1 << win);
            #1;
            chk("R3 busy rejects", 32'(req_accept), 0);
            chk("R3 no engine issue while busy", 32'(eng_req_valid), 0);
            chk("R7 no retry while busy", 32'(retry), 0);
            cyc();
            req_valid = '0;
            eng_rsp_valid = 1'b1;
            eng_rsp_data = 8'(8'hC0 + m);
            #1;
            chk("R5 response routed", 32'(rsp_valid), 32'(1 << win));
            chk("R5 response data", 32'(rsp_data[win*8 +: 8]), 32'(8'hC0 + m));
            cyc();
            eng_rsp_valid = 1'b0;
            #1;
            chk("R10 all owed ports retry", 32'(retry), 32'(m));
            cyc();
            #1;
            chk("R7 retry is one pulse", 32'(retry), 0);
        end

        // Held response on port 1
        cyc();
        req_valid = 3'b010; req_data[15:8] = 8'h11;
        #1;
        chk("R2 single request accepted", 32'(req_accept), 32'b010);
        rr = 2;
        cyc();
        req_valid = '0; eng_rsp_valid = 1'b1; eng_rsp_data = 8'h5A; rsp_ready = 3'b101;
        #1;
        chk("R5 refused response still shown", 32'(rsp_valid), 32'b010);
        cyc();
        eng_rsp_valid = 1'b0; eng_rsp_data = 8'h00; req_valid = 3'b010;
        #1;
        chk("R6 held response valid", 32'(rsp_valid), 32'b010);
        chk("R6 held response data", 32'(rsp_data[15:8]), 32'h5A);
        chk("R6 holding port rejects", 32'(req_accept), 0);
        chk("R7 no retry while holding", 32'(retry), 0);
        cyc();
        req_valid = '0; rsp_ready = 3'b111;
        #1;
        chk("R6 redelivery", 32'(rsp_valid), 32'b010);
        cyc();
        #1;
        chk("R6 hold drained", 32'(rsp_valid), 0);
        chk("R7 retry after drain", 32'(retry), 32'b010);
        cyc();
        #1;
        chk("R7 drain retry pulse ends", 32'(retry), 0);

        // Owed port rejects even with engine idle
        cyc();
        req_valid = 3'b001; req_data[7:0] = 8'h21;
        #1;
        chk("R4 pointer after port 1", 32'(req_accept), 32'b001);
        cyc();
        req_valid = 3'b100; req_data[23:16] = 8'h33;
        #1;
        chk("R3 port 2 rejected while busy", 32'(req_accept), 0);
        cyc();
        req_valid = '0; eng_rsp_valid = 1'b1; eng_rsp_data = 8'h44;
        cyc();
        eng_rsp_valid = 1'b0; req_valid = 3'b100;
        #1;
        chk("R8 retry shown", 32'(retry), 32'b100);
        chk("R8 owed port rejected while idle", 32'(req_accept), 0);
        cyc();
        req_valid = '0;
        #1;
        chk("R8 rejection keeps retry owed", 32'(retry), 32'b100);
        cyc();
        req_valid = 3'b100;
        #1;
        chk("R8 accepted after retry", 32'(req_accept), 32'b100);
        rr = 0;

        // Same-cycle reuse when response arrives
        cyc();
        req_valid = 3'b000;
        cyc();
        req_valid = 3'b100; req_data[23:16] = 8'h55;
        eng_rsp_valid = 1'b1; eng_rsp_data = 8'h66; rsp_ready = 3'b111;
        #1;
        chk("R9 owner re-request accepted", 32'(req_accept), 32'b100);
        chk("R9 response delivered", 32'(rsp_valid), 32'b100);
        chk("R9 engine gets new payload", 32'(eng_req_data), 32'h55);
        rr = 0;
        cyc();
        req_valid = 3'b101; req_data[7:0] = 8'h77;
        eng_rsp_valid = 1'b1; eng_rsp_data = 8'h88; rsp_ready = 3'b011;
        #1;
        chk("R9 refusing owner rejected, other port taken", 32'(req_accept), 32'b001);
        rr = 1;
        cyc();
        req_valid = '0; rsp_ready = 3'b111; eng_rsp_valid = 1'b1; eng_rsp_data = 8'h99;
        #1;
        chk("R5 two ports valid (held plus fresh)", 32'(rsp_valid), 32'b101);
        chk("R5 fresh data to port 0", 32'(rsp_data[7:0]), 32'h99);
        chk("R6 held data on port 2", 32'(rsp_data[23:16]), 32'h88);
        cyc();
        eng_rsp_valid = 1'b0;
        #1;
        chk("R10 retry for owed port", 32'(retry), 32'b100);
        cyc();
        #1;
        chk("R7 final retry ends", 32'(retry), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule